// File: doc/BRIEF.md
# Four-Thread Interleaved Issue Selector

This block sits at the thread-choice stage of a single-issue core that runs four hardware threads and may change thread on every clock. In each cycle it looks at which threads have an instruction waiting and are free to go. It picks the one that has gone longest without being chosen and reports that thread on a registered issue port. A change of thread costs nothing, because each thread keeps its own program counter, registers and buffers outside this block.

A thread drops out of the race for three reasons. Its waiting instruction may be long-latency, it may be in a load's result shadow, or an outside stall or trap may hold it. A load makes its thread skip the next two choices. After that the thread may issue again straight away, on the bet that the load hit. If a miss is later reported for that thread, any instruction it already issued past the load is marked for flush. The thread then waits for a miss-done pulse.

Top module: `thread_pick_stage`

## Requirements
- R1: While reset is high, and on the first clock edge after it, issue_vld and flush_vld are 0. The recency order after reset is thread 0 (oldest), then 1, 2 and 3, so with all threads ready the picks run 0, 1, 2, 3.
- R2: Among the threads that are ready in a cycle, the selector picks the one chosen least recently. Its number appears on issue_tid with issue_vld high after the next clock edge, and that thread becomes the most recently chosen.
- R3: A thread is ready only if its buf_valid bit is 1 and its stall and trap bits are 0 in that cycle.
- R4: In a cycle with no ready thread, issue_vld is 0 after the next edge and the recency order does not change.
- R5: head_cls codes are 1 for load, 2 for branch, 3 for multiply, 4 for divide, and any other value for a plain instruction. A thread that issues a load is not ready in the two cycles after it issues.
- R6: A thread that issues a branch, multiply or divide stays not ready until a lop_done pulse for that thread. The thread is ready again from the cycle after the pulse.
- R7: In the third cycle after issuing a load, the thread may issue again without any load result. That next instruction counts as speculative until the thread issues another instruction or a miss is reported for it.
- R8: A miss (ld_miss high, thread ld_miss_tid) blocks that thread in the same cycle and every cycle after it, until a miss_done pulse for that thread. The thread is ready again from the cycle after the pulse; a miss in the same cycle wins over miss_done. If that thread holds a speculative instruction, flush_vld is 1 with flush_tid equal to the thread after the next edge.
- R9: All outputs are registered. A decision made from the inputs of one cycle shows on the outputs after the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_valid | input | NTHR | Per-thread: an instruction is waiting in the buffer |
| head_cls | input | 3*NTHR | Per-thread class code of the waiting instruction |
| stall | input | NTHR | Per-thread stall (cache miss, resource conflict) |
| trap | input | NTHR | Per-thread trap hold |
| lop_done | input | NTHR | Per-thread completion pulse for branch, multiply or divide |
| ld_miss | input | 1 | A load miss is reported this cycle |
| ld_miss_tid | input | log2(NTHR) | Thread of the reported miss |
| miss_done | input | NTHR | Per-thread pulse: miss has been serviced |
| issue_vld | output | 1 | An instruction was selected |
| issue_tid | output | log2(NTHR) | Selected thread |
| flush_vld | output | 1 | Speculative instruction of a thread must be flushed |
| flush_tid | output | log2(NTHR) | Thread to flush |

## Verification
The collision that matters most is a miss report for a thread in the same cycle that the thread would otherwise win the pick, or in the same cycle as that thread's miss-done pulse. A close second is a completion pulse that lands in the very cycle its thread issues a new long-latency instruction. Random phases with high miss, miss-done and completion rates make these overlaps frequent. A behavioural model compares each overlap cycle by cycle, checking which thread issues and whether a flush is raised. Checker properties confirm that a thread reported as missing never issues in that cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int CLSW = 3;

  typedef enum logic [CLSW-1:0] {
    CLS_PLAIN  = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_BRANCH = 3'd2,
    CLS_MUL    = 3'd3,
    CLS_DIV    = 3'd4
  } instr_cls_e;

  function automatic logic is_long(input logic [CLSW-1:0] c);
    return (c == CLS_BRANCH) || (c == CLS_MUL) || (c == CLS_DIV);
  endfunction
endpackage

// File: rtl/tps_thread_state.sv
module tps_thread_state
  import tps_pkg::*;
#(
  parameter int SHADOW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            buf_v,
  input  logic            stall,
  input  logic            trap,
  input  logic            issue,
  input  logic [CLSW-1:0] cls,
  input  logic            lop_done,
  input  logic            miss,
  input  logic            miss_done,
  output logic            rdy,
  output logic            flush_req
);
  localparam int SHW = $clog2(SHADOW + 1);

  logic [SHW-1:0] shadow_q;
  logic           lop_wait_q;
  logic           miss_wait_q;
  logic           ld_pend_q;
  logic           spec_q;

  assign rdy = buf_v && !stall && !trap && !lop_wait_q && !miss_wait_q
               && (shadow_q == '0) && !miss;
  assign flush_req = miss && spec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q    <= '0;
      lop_wait_q  <= 1'b0;
      miss_wait_q <= 1'b0;
      ld_pend_q   <= 1'b0;
      spec_q      <= 1'b0;
    end else begin
      if (issue && cls == CLS_LOAD) shadow_q <= SHW'(SHADOW);
      else if (shadow_q != '0)      shadow_q <= shadow_q - 1'b1;

      if (issue && is_long(cls)) lop_wait_q <= 1'b1;
      else if (lop_done)         lop_wait_q <= 1'b0;

      if (miss) begin
        miss_wait_q <= 1'b1;
        spec_q      <= 1'b0;
        ld_pend_q   <= 1'b0;
      end else begin
        if (miss_done) miss_wait_q <= 1'b0;
        if (issue) begin
          if (cls == CLS_LOAD) begin
            ld_pend_q <= 1'b1;
            spec_q    <= 1'b0;
          end else begin
            spec_q    <= ld_pend_q;
            ld_pend_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tps_lru.sv
module tps_lru #(
  parameter int NTHR = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NTHR-1:0]         rdy,
  output logic                    hit,
  output logic [$clog2(NTHR)-1:0] pick
);
  localparam int TIDW = $clog2(NTHR);

  logic [TIDW-1:0] order_q [NTHR];
  logic [TIDW-1:0] pos;

  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int k = NTHR - 1; k >= 0; k--) begin
      if (rdy[order_q[k]]) begin
        hit = 1'b1;
        pos = TIDW'(k);
      end
    end
    pick = order_q[pos];
  end

  for (genvar k = 0; k < NTHR; k++) begin : g_slot
    if (k < NTHR - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)                          order_q[k] <= TIDW'(k);
        else if (hit && TIDW'(k) >= pos)  order_q[k] <= order_q[k+1];
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)      order_q[k] <= TIDW'(k);
        else if (hit) order_q[k] <= pick;
      end
    end
  end
endmodule

// File: rtl/thread_pick_stage.sv
module thread_pick_stage
  import tps_pkg::*;
#(
  parameter int NTHR        = 4,
  parameter int LOAD_SHADOW = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NTHR-1:0]         buf_valid,
  input  logic [NTHR*3-1:0]       head_cls,
  input  logic [NTHR-1:0]         stall,
  input  logic [NTHR-1:0]         trap,
  input  logic [NTHR-1:0]         lop_done,
  input  logic                    ld_miss,
  input  logic [$clog2(NTHR)-1:0] ld_miss_tid,
  input  logic [NTHR-1:0]         miss_done,
  output logic                    issue_vld,
  output logic [$clog2(NTHR)-1:0] issue_tid,
  output logic                    flush_vld,
  output logic [$clog2(NTHR)-1:0] flush_tid
);
  localparam int TIDW = $clog2(NTHR);

  logic [NTHR-1:0] rdy;
  logic [NTHR-1:0] flush_req;
  logic            hit;
  logic [TIDW-1:0] pick;

  tps_lru #(.NTHR(NTHR)) u_lru (
    .clk  (clk),
    .rst  (rst),
    .rdy  (rdy),
    .hit  (hit),
    .pick (pick)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    tps_thread_state #(.SHADOW(LOAD_SHADOW)) u_st (
      .clk       (clk),
      .rst       (rst),
      .buf_v     (buf_valid[t]),
      .stall     (stall[t]),
      .trap      (trap[t]),
      .issue     (hit && pick == TIDW'(t)),
      .cls       (head_cls[t*CLSW +: CLSW]),
      .lop_done  (lop_done[t]),
      .miss      (ld_miss && ld_miss_tid == TIDW'(t)),
      .miss_done (miss_done[t]),
      .rdy       (rdy[t]),
      .flush_req (flush_req[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_vld <= 1'b0;
      issue_tid <= '0;
      flush_vld <= 1'b0;
      flush_tid <= '0;
    end else begin
      issue_vld <= hit;
      if (hit) issue_tid <= pick;
      flush_vld <= |flush_req;
      if (|flush_req) flush_tid <= ld_miss_tid;
    end
  end
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int NTHR = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NTHR-1:0]         buf_valid,
  input logic [NTHR*3-1:0]       head_cls,
  input logic [NTHR-1:0]         stall,
  input logic [NTHR-1:0]         trap,
  input logic                    ld_miss,
  input logic [$clog2(NTHR)-1:0] ld_miss_tid,
  input logic                    issue_vld,
  input logic [$clog2(NTHR)-1:0] issue_tid,
  input logic                    flush_vld,
  input logic [$clog2(NTHR)-1:0] flush_tid
);
  localparam int TIDW = $clog2(NTHR);

  logic [NTHR-1:0]   bv_q, stall_q, trap_q;
  logic [NTHR*3-1:0] cls_q;
  logic              miss_q;
  logic [TIDW-1:0]   miss_tid_q;
  logic [2:0]        iss_cls;

  always_ff @(posedge clk) begin
    bv_q       <= buf_valid;
    stall_q    <= stall;
    trap_q     <= trap;
    cls_q      <= head_cls;
    miss_q     <= ld_miss;
    miss_tid_q <= ld_miss_tid;
  end

  assign iss_cls = cls_q[issue_tid*3 +: 3];

  assert_ready_gate_R3: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> (bv_q[issue_tid] && !stall_q[issue_tid] && !trap_q[issue_tid]));

  assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (bv_q == '0) |-> !issue_vld);

  assert_load_shadow1_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && iss_cls == 3'd1) |=> !(issue_vld && issue_tid == $past(issue_tid)));

  assert_load_shadow2_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && iss_cls == 3'd1) |=> ##1 !(issue_vld && issue_tid == $past(issue_tid, 2)));

  assert_long_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && (iss_cls == 3'd2 || iss_cls == 3'd3 || iss_cls == 3'd4))
    |=> !(issue_vld && issue_tid == $past(issue_tid)));

  assert_flush_source_R8: assert property (@(posedge clk) disable iff (rst)
    flush_vld |-> (miss_q && flush_tid == miss_tid_q));

  assert_miss_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (miss_q && issue_vld) |-> (issue_tid != miss_tid_q));
endmodule

bind thread_pick_stage tps_checker #(.NTHR(NTHR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .buf_valid   (buf_valid),
  .head_cls    (head_cls),
  .stall       (stall),
  .trap        (trap),
  .ld_miss     (ld_miss),
  .ld_miss_tid (ld_miss_tid),
  .issue_vld   (issue_vld),
  .issue_tid   (issue_tid),
  .flush_vld   (flush_vld),
  .flush_tid   (flush_tid)
);

// File: tb/sim_thread_pick_stage.sv
module sim_thread_pick_stage;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] buf_valid = '0, stall = '0, trap = '0, lop_done = '0, miss_done = '0;
  logic [N*3-1:0] head_cls = '0;
  logic         ld_miss = 1'b0;
  logic [1:0]   ld_miss_tid = '0;
  logic         issue_vld, flush_vld;
  logic [1:0]   issue_tid, flush_tid;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  int q[$];
  int shd[N], lopw[N], missw[N], ldp[N], spec[N];
  bit e_iv, e_fv;
  int e_tid, e_ft;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_pick_stage #(.NTHR(N), .LOAD_SHADOW(2)) u0 (
    .clk(clk), .rst(rst), .buf_valid(buf_valid), .head_cls(head_cls),
    .stall(stall), .trap(trap), .lop_done(lop_done), .ld_miss(ld_miss),
    .ld_miss_tid(ld_miss_tid), .miss_done(miss_done), .issue_vld(issue_vld),
    .issue_tid(issue_tid), .flush_vld(flush_vld), .flush_tid(flush_tid));

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q = {0, 1, 2, 3};
      for (int t = 0; t < N; t++) begin
        shd[t] = 0; lopw[t] = 0; missw[t] = 0; ldp[t] = 0; spec[t] = 0;
      end
      e_iv = 0; e_fv = 0;
    end else begin
      bit rdy[N];
      int pick, pidx;
      pick = -1; pidx = -1;
      for (int t = 0; t < N; t++)
        rdy[t] = buf_valid[t] && !stall[t] && !trap[t] && lopw[t] == 0 && missw[t] == 0
                 && shd[t] == 0 && !(ld_miss && ld_miss_tid == t);
      foreach (q[i]) if (pidx < 0 && rdy[q[i]]) pidx = i;
      if (pidx >= 0) begin
        pick = q[pidx];
        q.delete(pidx);
        q.push_back(pick);
        e_tid = pick;
      end
      e_iv = (pick >= 0);
      e_fv = 0;
      for (int t = 0; t < N; t++) begin
        int c;
        bit lng;
        c = head_cls[t*3 +: 3];
        lng = (c >= 2 && c <= 4);
        if (t == pick) begin
          if (c == 1) begin shd[t] = 2; ldp[t] = 1; spec[t] = 0; end
          else begin spec[t] = ldp[t]; ldp[t] = 0; end
        end else if (shd[t] > 0) shd[t]--;
        if (t == pick && lng) lopw[t] = 1;
        else if (lop_done[t]) lopw[t] = 0;
        if (ld_miss && ld_miss_tid == t) begin
          if (spec[t] != 0) begin e_fv = 1; e_ft = t; end
          missw[t] = 1; spec[t] = 0; ldp[t] = 0;
        end else if (miss_done[t]) missw[t] = 0;
      end
    end
  end

  task automatic compare();
    n_cmp++;
    if (issue_vld !== e_iv || (e_iv && issue_tid !== 2'(e_tid))) begin
      n_bad++;
      $display("FAIL %s: issue vld/tid = %0b/%0d, expected %0b/%0d", tag, issue_vld, issue_tid, e_iv, e_tid);
    end
    if (flush_vld !== e_fv || (e_fv && flush_tid !== 2'(e_ft))) begin
      n_bad++;
      $display("FAIL %s: flush vld/tid = %0b/%0d, expected %0b/%0d", tag, flush_vld, flush_tid, e_fv, e_ft);
    end
  endtask

  task automatic run(input string t, input int n, input int p_bv, input int p_st, input int p_tr,
                     input int p_ld, input int p_lg, input int p_dn, input int p_ms, input int p_md);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      for (int k = 0; k < N; k++) begin
        int r;
        buf_valid[k] = ($urandom_range(99, 0) < p_bv);
        stall[k]     = ($urandom_range(99, 0) < p_st);
        trap[k]      = ($urandom_range(99, 0) < p_tr);
        lop_done[k]  = ($urandom_range(99, 0) < p_dn);
        miss_done[k] = ($urandom_range(99, 0) < p_md);
        r = $urandom_range(99, 0);
        if (r < p_ld)             head_cls[k*3 +: 3] = 3'd1;
        else if (r < p_ld + p_lg) head_cls[k*3 +: 3] = 3'(2 + $urandom_range(2, 0));
        else                      head_cls[k*3 +: 3] = 3'($urandom_range(1, 0) * 5);
      end
      ld_miss     = ($urandom_range(99, 0) < p_ms);
      ld_miss_tid = 2'($urandom_range(3, 0));
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_cmp++;
    if (issue_vld !== 1'b0 || flush_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset outputs issue=%0b flush=%0b, expected 0/0", issue_vld, flush_vld);
    end
    buf_valid = '1;
    rst = 1'b0;
    // R1, R2: all ready, plain work -> picks 0,1,2,3,0...
    run("R1", 12, 100, 0, 0, 0, 0, 0, 0, 0);
    run("R2", 40, 60, 0, 0, 0, 0, 0, 0, 0);
    run("R3", 300, 75, 25, 15, 0, 0, 0, 0, 0);
    run("R4", 300, 12, 10, 5, 0, 0, 0, 0, 0);
    run("R5", 400, 90, 5, 0, 70, 0, 0, 0, 0);
    run("R6", 400, 90, 5, 5, 0, 50, 25, 0, 0);
    run("R7", 400, 100, 0, 0, 80, 0, 0, 0, 0);
    run("R8", 1500, 90, 5, 5, 50, 10, 30, 25, 30);
    run("R9", 3000, 80, 10, 5, 30, 25, 30, 15, 25);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d, expected under %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule